// File: doc/BRIEF.md
# Dual-Edge Output Register Cell

This block is an output storage cell for a chip pad. It drives data on both clock edges. One register loads `d1` on the rising edge of `clk` and a second register loads `d2` on the falling edge. A multiplexer selected by the clock level puts the most recently written register on `q`. If `d1` is tied high and `d2` is tied low, `q` becomes a copy of the clock. That copy passes through the same registers and multiplexer as ordinary data, so it shows the same delay.

Both registers share three control inputs: a clock enable, a force input, and a reverse-force input. Parameters fixed at elaboration set the behaviour:

- the active level of each control input,
- whether the clock enable is wired at all,
- the value the force input drives (`SR_TARGET_HIGH`),
- the value loaded by the global initialise input (`INIT_HIGH`), chosen independently of the force value,
- whether forcing is synchronous or asynchronous, for the whole cell.

The reverse-force input drives the opposite of the force value. When both are active, the register goes to 0. The `WIDTH` lanes share all controls.

Top module: `ddr_out_cell`

## Requirements
- R1: On a rising `clk` edge the rise register loads `d1`. On a falling edge the fall register loads `d2`. `q` shows the rise register while `clk` is 1 and the fall register while `clk` is 0.
- R2: With `d1` all ones and `d2` all zeros and the enable active, `q` is all ones in the high clock phase and all zeros in the low phase.
- R3: With `CE_USED`=1, an inactive `ceIn` makes both registers hold their value. With `CE_USED`=0, `ceIn` is ignored and every edge loads.
- R4: An active force input (`srIn`) drives both registers to `SR_TARGET_HIGH` on every lane.
- R5: An active reverse input (`revIn`) with the force input inactive drives both registers to the inverse of `SR_TARGET_HIGH`.
- R6: When the force and reverse inputs are both active, the registers go to 0, whatever `SR_TARGET_HIGH` is.
- R7: `gInit`=1 loads `INIT_HIGH` into both registers asynchronously. It overrides the clock, the enable, the force input and the reverse input, and `INIT_HIGH` does not depend on `SR_TARGET_HIGH`.
- R8: With `ASYNC_MODE`=0, the force and reverse inputs act only at each register's own clock edge, and they act there even when the enable is inactive.
- R9: With `ASYNC_MODE`=1, the force and reverse inputs change the registers at once, with no clock edge.
- R10: `ceIn`, `srIn` and `revIn` are each active at the level set by `CE_ACT_HIGH`, `SR_ACT_HIGH` and `REV_ACT_HIGH` (1 = active high, 0 = active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; rising edge writes the rise register, falling edge writes the fall register, level selects the output |
| gInit | input | 1 | Asynchronous global initialise, active high |
| ceIn | input | 1 | Shared clock enable, polarity set by parameter |
| srIn | input | 1 | Force to `SR_TARGET_HIGH`, polarity set by parameter |
| revIn | input | 1 | Force to the inverse value, polarity set by parameter |
| d1 | input | WIDTH | Data captured on the rising edge |
| d2 | input | WIDTH | Data captured on the falling edge |
| q | output | WIDTH | Dual-edge output |

## Verification
The bench runs two configurations side by side: a synchronous cell with a low force target and a high initial value, and an asynchronous cell with the opposite choices and no enable wired. It asserts force and reverse together, which exposes a design that lets the set win or that decodes "reset" from the target attribute. It asserts the force input in the middle of a low clock phase. That catches a synchronous cell that reacts too early and an asynchronous cell that waits for an edge. It also covers a disabled enable combined with force, the init input held while force is active, the clock-mirror pattern sampled in both phases, and inverted control polarities. These show up, in turn, as forcing gated by the enable, force winning over init, swapped output phases, and controls read at the wrong level.

// File: rtl/ddr_cell_pkg.sv
package ddr_cell_pkg;
  // Strobes from the control decoder to the register datapath, all active high.
  typedef struct packed {
    logic load;       // capture data on the register's edge
    logic forceZero;  // drive the register to 0 (wins over forceOne)
    logic forceOne;   // drive the register to 1
  } cellStrobes_t;
endpackage

// File: rtl/ddr_cell_ctrl.sv
module ddr_cell_ctrl
  import ddr_cell_pkg::*;
#(
  parameter bit CE_USED        = 1'b1,
  parameter bit CE_ACT_HIGH    = 1'b1,
  parameter bit SR_ACT_HIGH    = 1'b1,
  parameter bit REV_ACT_HIGH   = 1'b1,
  parameter bit USE_SR         = 1'b1,
  parameter bit USE_REV        = 1'b1,
  parameter bit SR_TARGET_HIGH = 1'b0
) (
  input  logic         ceIn,
  input  logic         srIn,
  input  logic         revIn,
  output cellStrobes_t strobes
);
  logic ceActive;
  logic srActive;
  logic revActive;

  // Polarity absorption: each control compared against its own active level.
  generate
    if (CE_USED) begin : g_ce
      assign ceActive = (ceIn == CE_ACT_HIGH);
    end else begin : g_noCe
      assign ceActive = 1'b1;
    end
    if (USE_SR) begin : g_sr
      assign srActive = (srIn == SR_ACT_HIGH);
    end else begin : g_noSr
      assign srActive = 1'b0;
    end
    if (USE_SR && USE_REV) begin : g_rev
      assign revActive = (revIn == REV_ACT_HIGH);
    end else begin : g_noRev
      assign revActive = 1'b0;
    end
  endgenerate

  // The input that drives 0 is the reset; it wins over the one that drives 1.
  always_comb begin
    strobes.load      = ceActive;
    strobes.forceZero = SR_TARGET_HIGH ? revActive : srActive;
    strobes.forceOne  = (SR_TARGET_HIGH ? srActive : revActive) & ~strobes.forceZero;
  end
endmodule

// File: rtl/ddr_cell_path.sv
module ddr_cell_path
  import ddr_cell_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit ASYNC_MODE = 1'b0,
  parameter bit INIT_HIGH  = 1'b0
) (
  input  logic             clk,
  input  logic             gInit,
  input  cellStrobes_t     strobes,
  input  logic [WIDTH-1:0] d1,
  input  logic [WIDTH-1:0] d2,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] InitWord = {WIDTH{INIT_HIGH}};

  logic [WIDTH-1:0] regRise;
  logic [WIDTH-1:0] regFall;
  logic forceZero;
  logic forceOne;
  logic loadEn;

  assign forceZero = strobes.forceZero;
  assign forceOne  = strobes.forceOne;
  assign loadEn    = strobes.load;

  generate
    if (ASYNC_MODE) begin : g_async
      always_ff @(posedge clk or posedge gInit or posedge forceZero or posedge forceOne) begin
        if (gInit)          regRise <= InitWord;
        else if (forceZero) regRise <= '0;
        else if (forceOne)  regRise <= '1;
        else if (loadEn)    regRise <= d1;
      end
      always_ff @(negedge clk or posedge gInit or posedge forceZero or posedge forceOne) begin
        if (gInit)          regFall <= InitWord;
        else if (forceZero) regFall <= '0;
        else if (forceOne)  regFall <= '1;
        else if (loadEn)    regFall <= d2;
      end
    end else begin : g_sync
      always_ff @(posedge clk or posedge gInit) begin
        if (gInit)          regRise <= InitWord;
        else if (forceZero) regRise <= '0;
        else if (forceOne)  regRise <= '1;
        else if (loadEn)    regRise <= d1;
      end
      always_ff @(negedge clk or posedge gInit) begin
        if (gInit)          regFall <= InitWord;
        else if (forceZero) regFall <= '0;
        else if (forceOne)  regFall <= '1;
        else if (loadEn)    regFall <= d2;
      end
    end
  endgenerate

  // Clock level selects the register written most recently.
  assign q = clk ? regRise : regFall;
endmodule

// File: rtl/ddr_out_cell.sv
module ddr_out_cell
  import ddr_cell_pkg::*;
#(
  parameter int WIDTH          = 4,
  parameter bit ASYNC_MODE     = 1'b0,
  parameter bit SR_TARGET_HIGH = 1'b0,
  parameter bit INIT_HIGH      = 1'b0,
  parameter bit CE_USED        = 1'b1,
  parameter bit CE_ACT_HIGH    = 1'b1,
  parameter bit SR_ACT_HIGH    = 1'b1,
  parameter bit REV_ACT_HIGH   = 1'b1,
  parameter bit USE_SR         = 1'b1,
  parameter bit USE_REV        = 1'b1
) (
  input  logic             clk,
  input  logic             gInit,
  input  logic             ceIn,
  input  logic             srIn,
  input  logic             revIn,
  input  logic [WIDTH-1:0] d1,
  input  logic [WIDTH-1:0] d2,
  output logic [WIDTH-1:0] q
);
  cellStrobes_t strobes;

  ddr_cell_ctrl #(
    .CE_USED(CE_USED), .CE_ACT_HIGH(CE_ACT_HIGH), .SR_ACT_HIGH(SR_ACT_HIGH),
    .REV_ACT_HIGH(REV_ACT_HIGH), .USE_SR(USE_SR), .USE_REV(USE_REV),
    .SR_TARGET_HIGH(SR_TARGET_HIGH)
  ) ctrl_i (
    .ceIn(ceIn), .srIn(srIn), .revIn(revIn), .strobes(strobes)
  );

  ddr_cell_path #(
    .WIDTH(WIDTH), .ASYNC_MODE(ASYNC_MODE), .INIT_HIGH(INIT_HIGH)
  ) path_i (
    .clk(clk), .gInit(gInit), .strobes(strobes), .d1(d1), .d2(d2), .q(q)
  );
endmodule

// File: rtl/ddr_cell_chk.sv
module ddr_cell_chk #(
  parameter int WIDTH          = 4,
  parameter bit ASYNC_MODE     = 1'b0,
  parameter bit SR_TARGET_HIGH = 1'b0,
  parameter bit INIT_HIGH      = 1'b0,
  parameter bit CE_USED        = 1'b1,
  parameter bit CE_ACT_HIGH    = 1'b1,
  parameter bit SR_ACT_HIGH    = 1'b1,
  parameter bit REV_ACT_HIGH   = 1'b1,
  parameter bit USE_SR         = 1'b1,
  parameter bit USE_REV        = 1'b1
) (
  input logic             clk,
  input logic             gInit,
  input logic             ceIn,
  input logic             srIn,
  input logic             revIn,
  input logic [WIDTH-1:0] d1,
  input logic [WIDTH-1:0] d2,
  input logic [WIDTH-1:0] q
);
  logic srA, revA, ceA;
  assign srA  = USE_SR && (srIn == SR_ACT_HIGH);
  assign revA = USE_SR && USE_REV && (revIn == REV_ACT_HIGH);
  assign ceA  = !CE_USED || (ceIn == CE_ACT_HIGH);

  // Controls seen at the last rising edge; checked at the next falling edge.
  logic capValid, capSr, capRev, capCe;
  logic [WIDTH-1:0] capD;
  always_ff @(posedge clk or posedge gInit) begin
    if (gInit) capValid <= 1'b0;
    else       capValid <= 1'b1;
  end
  always_ff @(posedge clk) begin
    capSr  <= srA;
    capRev <= revA;
    capCe  <= ceA;
    capD   <= d1;
  end

  a_r1_r8_load: assert property (@(negedge clk) disable iff (gInit)
    (capValid && !capSr && !capRev && capCe && (!ASYNC_MODE || (!srA && !revA))) |-> q == capD);

  a_r4_sr_target: assert property (@(negedge clk) disable iff (gInit)
    (capValid && capSr && !capRev) |-> q == {WIDTH{SR_TARGET_HIGH}});

  a_r5_rev_opposite: assert property (@(negedge clk) disable iff (gInit)
    (capValid && capRev && !capSr) |-> q == {WIDTH{!SR_TARGET_HIGH}});

  a_r6_reset_wins: assert property (@(negedge clk) disable iff (gInit)
    (capValid && capSr && capRev) |-> q == '0);

  a_r9_async_force: assert property (@(negedge clk) disable iff (gInit)
    (ASYNC_MODE && srA && !revA) |-> q == {WIDTH{SR_TARGET_HIGH}});

  a_r7_init: assert property (@(posedge clk)
    gInit |-> q == {WIDTH{INIT_HIGH}});
endmodule

bind ddr_out_cell ddr_cell_chk #(
  .WIDTH(WIDTH), .ASYNC_MODE(ASYNC_MODE), .SR_TARGET_HIGH(SR_TARGET_HIGH),
  .INIT_HIGH(INIT_HIGH), .CE_USED(CE_USED), .CE_ACT_HIGH(CE_ACT_HIGH),
  .SR_ACT_HIGH(SR_ACT_HIGH), .REV_ACT_HIGH(REV_ACT_HIGH), .USE_SR(USE_SR),
  .USE_REV(USE_REV)
) chk_i (
  .clk(clk), .gInit(gInit), .ceIn(ceIn), .srIn(srIn), .revIn(revIn),
  .d1(d1), .d2(d2), .q(q)
);

// File: tb/ddr_out_cell_tb_top.sv
module ddr_out_cell_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic gInit, ceIn, srInA, revInA, srInB, revInB;
  logic [W-1:0] d1, d2, qA, qB;

  // A: synchronous, force target 0, init 1, enable wired active high, reverse active low.
  ddr_out_cell #(.WIDTH(W), .ASYNC_MODE(1'b0), .SR_TARGET_HIGH(1'b0), .INIT_HIGH(1'b1),
    .CE_USED(1'b1), .CE_ACT_HIGH(1'b1), .SR_ACT_HIGH(1'b1), .REV_ACT_HIGH(1'b0))
  dut_i (.clk(clk), .gInit(gInit), .ceIn(ceIn), .srIn(srInA), .revIn(revInA),
         .d1(d1), .d2(d2), .q(qA));

  // B: asynchronous, force target 1, init 0, no enable, force active low.
  ddr_out_cell #(.WIDTH(W), .ASYNC_MODE(1'b1), .SR_TARGET_HIGH(1'b1), .INIT_HIGH(1'b0),
    .CE_USED(1'b0), .CE_ACT_HIGH(1'b1), .SR_ACT_HIGH(1'b0), .REV_ACT_HIGH(1'b1))
  dutB_i (.clk(clk), .gInit(gInit), .ceIn(ceIn), .srIn(srInB), .revIn(revInB),
          .d1(d1), .d2(d2), .q(qB));

  typedef struct { string tag; logic [W-1:0] expA; logic [W-1:0] expB; } item_t;
  item_t sbq[$];
  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] rA, fA, rB, fB;  // bench model of the four registers

  // Monitor: pops each expected item and compares against both outputs.
  initial begin
    forever begin
      item_t it;
      wait (sbq.size() != 0);
      it = sbq.pop_front();
      vectors++;
      if (qA !== it.expA) begin
        miscompares++;
        $display("FAIL %s (sync cell): q=%h expected %h", it.tag, qA, it.expA);
      end
      if (qB !== it.expB) begin
        miscompares++;
        $display("FAIL %s (async cell): q=%h expected %h", it.tag, qB, it.expB);
      end
    end
  end

  function automatic logic [W-1:0] nxt(input logic [W-1:0] cur, input logic [W-1:0] d,
      input bit srOn, input bit revOn, input bit ceOn, input bit tgt, input bit ceUsed);
    if (srOn && revOn)        return '0;            // R6
    else if (srOn)            return {W{tgt}};      // R4
    else if (revOn)           return {W{!tgt}};     // R5
    else if (ceOn || !ceUsed) return d;             // R1, R3
    else                      return cur;
  endfunction

  // Logical control levels mapped to each cell's raw polarity (R10).
  task automatic setCtl(input bit srOn, input bit revOn, input bit ceOn);
    srInA = srOn;  revInA = !revOn;
    srInB = !srOn; revInB = revOn;
    ceIn  = ceOn;
  endtask

  task automatic push(input string tag, input logic [W-1:0] a, input logic [W-1:0] b);
    item_t it;
    it.tag = tag; it.expA = a; it.expB = b;
    sbq.push_back(it);
  endtask

  // Entered 2 ns after a falling edge; checks the rise phase then the fall phase.
  task automatic cyc(input logic [W-1:0] a, input logic [W-1:0] b,
      input bit srOn, input bit revOn, input bit ceOn, input string tag);
    d1 = a; d2 = b;
    setCtl(srOn, revOn, ceOn);
    @(posedge clk); #2;
    rA = nxt(rA, a, srOn, revOn, ceOn, 1'b0, 1'b1);
    rB = nxt(rB, a, srOn, revOn, ceOn, 1'b1, 1'b0);
    push({tag, " rise"}, rA, rB);
    @(negedge clk); #2;
    fA = nxt(fA, b, srOn, revOn, ceOn, 1'b0, 1'b1);
    fB = nxt(fB, b, srOn, revOn, ceOn, 1'b1, 1'b0);
    push({tag, " fall"}, fA, fB);
  endtask

  bit done = 1'b0;
  initial begin
    #(200000 * 8);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    gInit = 1'b1; d1 = '0; d2 = '0;
    setCtl(1'b0, 1'b0, 1'b1);
    repeat (2) @(posedge clk);
    #2 push("R7 init value high phase", 4'hF, 4'h0);
    @(negedge clk); #2 push("R7 init value low phase", 4'hF, 4'h0);
    gInit = 1'b0;
    rA = 4'hF; fA = 4'hF; rB = 4'h0; fB = 4'h0;

    cyc(4'hA, 4'h5, 0, 0, 1, "R1 R10 two-edge load");
    cyc(4'h3, 4'hC, 0, 0, 1, "R1 two-edge load b");
    cyc(4'hF, 4'h0, 0, 0, 1, "R2 clock mirror");
    cyc(4'hF, 4'h0, 0, 0, 1, "R2 clock mirror again");
    cyc(4'h6, 4'h9, 0, 0, 0, "R3 enable off holds / unwired loads");
    cyc(4'hA, 4'h5, 0, 0, 1, "R1 reload");
    cyc(4'h6, 4'h9, 1, 0, 1, "R4 R10 force");
    cyc(4'hA, 4'h5, 0, 0, 1, "R1 reload after force");
    cyc(4'h6, 4'h9, 1, 0, 0, "R8 force with enable off");
    cyc(4'h0, 4'h0, 0, 1, 1, "R5 reverse");
    cyc(4'hF, 4'hF, 0, 0, 1, "R1 fill ones");
    cyc(4'hA, 4'h5, 1, 1, 1, "R6 both active");
    cyc(4'h5, 4'h5, 0, 0, 1, "R1 load fives");

    // Force raised in mid low phase: sync cell waits for an edge, async cell reacts.
    setCtl(1'b1, 1'b0, 1'b1);
    #1 push("R8 R9 mid-phase force", fA, 4'hF);
    rB = 4'hF; fB = 4'hF;
    @(posedge clk); #2;
    rA = 4'h0;
    push("R8 R9 mid-phase force rise", rA, rB);
    @(negedge clk); #2;
    fA = 4'h0;
    push("R8 R9 mid-phase force fall", fA, fB);
    cyc(4'h9, 4'h6, 0, 0, 1, "R1 after mid-phase force");

    // Init held with both forces active and the clock running.
    setCtl(1'b1, 1'b1, 1'b1);
    gInit = 1'b1;
    #1 push("R7 init beats forces", 4'hF, 4'h0);
    @(posedge clk); #2 push("R7 init beats clock rise", 4'hF, 4'h0);
    @(negedge clk); #2 push("R7 init beats clock fall", 4'hF, 4'h0);
    setCtl(1'b0, 1'b0, 1'b1);
    gInit = 1'b0;
    rA = 4'hF; fA = 4'hF; rB = 4'h0; fB = 4'h0;
    cyc(4'h0, 4'h0, 0, 0, 0, "R3 hold init with enable off");
    cyc(4'h9, 4'h6, 0, 0, 1, "R1 load after init");

    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule